// File: doc/BRIEF.md
# Bit-Serial Node-Parallel Viterbi Decoder

This block is a maximum-likelihood decoder for a convolutional code of constraint length 4, i.e. eight trellis states. Every state owns an add-compare-select node. The nodes send their path metrics to each other over one-wire serial links, least significant bit first. A trellis step therefore takes many clocks, but the wiring between nodes stays at one wire per link. The generator taps are set by configuration inputs, so any rate 1/2 or rate 1/3 code of that constraint length can be decoded.

Each received group of soft symbols is offered with a valid/ready handshake. Each symbol is a 3-bit unsigned value: 0 means a confident 0 and 7 means a confident 1. For every accepted group the block computes branch metrics, runs the serial add-compare-select, and stores one survivor decision per state in a circular buffer. It then walks that buffer back from state 0 to deliver one decoded bit, pulsed with an output valid.

Top module: `vit_serial_dec`

## Requirements
- R1: `in_ready` is high exactly when the block is idle. A group offered with `in_valid` while ready is taken on that clock edge. `in_ready` then stays low for MW+TB+1 = 41 clocks before it rises again.
- R2: Let the encoder register be {u, u-1, u-2, u-3}, with the newest input u in bit 3. Coded bit j is the parity of generator j ANDed with that register. Over a clean channel, the decoded bits equal the encoder inputs for every non-catastrophic generator pair.
- R3: With `cfg_rate3` = 1, three coded bits per step are decoded from `in_sym0..2`. With `cfg_rate3` = 0, only `in_sym0`/`in_sym1` count and `in_sym2` has no effect on the decoded bits.
- R4: The branch metric is the sum over the coded bits in use of the soft distance. That distance is the symbol value when the expected bit is 0, and 7 minus the symbol value when it is 1. Isolated fully inverted symbols, at least 12 steps apart, are corrected.
- R5: When the two candidate metrics of a state are equal, the predecessor whose oldest register bit is 0 wins. With every branch metric equal, every decoded bit is 0.
- R6: When every new state metric has its top bit set at the end of a step, that bit is cleared in all of them. Runs of 140 steps with weak symbols (3 and 4) decode without error.
- R7: The first decoded bit appears after the 32nd accepted group, and then one bit follows per accepted group. Bit k is the encoder input of group k. `out_valid` is a single-clock pulse in the clock where `in_ready` returns.
- R8: After reset, `in_ready` is 1 and `out_valid` is 0, and all path metrics are zero.
- R9: Path metrics are 8-bit words added bit-serially with a carry that starts at zero for every word. The final carry of every candidate sum is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rate3 | input | 1 | 1 selects rate 1/3, 0 selects rate 1/2 |
| cfg_gen0 | input | 4 | Generator taps of coded bit 0 (bit 3 = newest input) |
| cfg_gen1 | input | 4 | Generator taps of coded bit 1 |
| cfg_gen2 | input | 4 | Generator taps of coded bit 2 (rate 1/3 only) |
| in_valid | input | 1 | A symbol group is offered |
| in_ready | output | 1 | The block accepts a group this clock |
| in_sym0 | input | 3 | Soft value of coded bit 0 |
| in_sym1 | input | 3 | Soft value of coded bit 1 |
| in_sym2 | input | 3 | Soft value of coded bit 2 |
| out_valid | output | 1 | One-clock pulse with a decoded bit |
| out_bit | output | 1 | Decoded bit |

## Verification
The assertions take for granted that the configuration inputs hold still from reset release to the end of a run, and that the metric spread stays small enough for a single top-bit clear to avoid any carry out. The spread bound holds for constraint length 4 with 3-bit symbols. The stimulus changes taps and rate only while reset is asserted. It drives symbols only from the legal 0..7 range, and holds `in_valid` for one clock while ready. Each run starts the encoder in state 0, so that early survivor paths agree with the all-zero starting metrics.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/vsd_bmu.sv
module vsd_bmu #(
    parameter int SW  = 3,
    parameter int BMW = 5
) (
    input  logic          rate3,
    input  logic [2:0]    exp_bits,
    input  logic [SW-1:0] sym0,
    input  logic [SW-1:0] sym1,
    input  logic [SW-1:0] sym2,
    output logic [BMW-1:0] metric
);
    localparam logic [SW-1:0] SMAX = '1;

    function automatic logic [BMW-1:0] soft_dist(input logic e, input logic [SW-1:0] s);
        logic [SW-1:0] d;
        d = e ? (SMAX - s) : s;
        return BMW'(d);
    endfunction

    always_comb begin
        metric = soft_dist(exp_bits[0], sym0) + soft_dist(exp_bits[1], sym1);
        if (rate3) begin
            metric = metric + soft_dist(exp_bits[2], sym2);
        end
    end
endmodule

// File: rtl/vsd_acs_node.sv
module vsd_acs_node #(
    parameter int K   = 4,
    parameter int SW  = 3,
    parameter int MW  = 8,
    parameter int BMW = 5,
    parameter int IW  = 3,
    parameter int IDX = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          first,
    input  logic          commit,
    input  logic          norm,
    input  logic          rate3,
    input  logic [K-1:0]  gen0,
    input  logic [K-1:0]  gen1,
    input  logic [K-1:0]  gen2,
    input  logic [SW-1:0] sym0,
    input  logic [SW-1:0] sym1,
    input  logic [SW-1:0] sym2,
    input  logic [IW-1:0] bit_idx,
    input  logic          pin0,
    input  logic          pin1,
    output logic          pout,
    output logic          dec,
    output logic          win_msb,
    output logic          pm_msb
);
    localparam int NS  = 2 ** (K - 1);
    localparam int SSW = K - 1;
    localparam logic [SSW-1:0] ME = SSW'(IDX);
    localparam logic [SSW-1:0] PA = SSW'((2 * IDX) % NS);
    localparam logic [SSW-1:0] PB = SSW'((2 * IDX + 1) % NS);

    typedef struct packed {
        logic [MW-1:0] pm;
        logic [MW-1:0] ca;
        logic [MW-1:0] cb;
        logic          cy_a;
        logic          cy_b;
        logic          brw;
    } node_t;

    node_t st_d, st_q;

    logic [K-1:0]   reg_a, reg_b;
    logic [2:0]     exp_a, exp_b;
    logic [BMW-1:0] bm_a, bm_b;
    logic [MW-1:0]  bm_a_w, bm_b_w, win;
    logic           ba, bb, cin_a, cin_b, s_a, s_b, bin;

    assign reg_a = {ME[SSW-1], PA};
    assign reg_b = {ME[SSW-1], PB};
    assign exp_a = {^(gen2 & reg_a), ^(gen1 & reg_a), ^(gen0 & reg_a)};
    assign exp_b = {^(gen2 & reg_b), ^(gen1 & reg_b), ^(gen0 & reg_b)};

    vsd_bmu #(.SW(SW), .BMW(BMW)) i_bmu_a (
        .rate3(rate3), .exp_bits(exp_a), .sym0(sym0), .sym1(sym1), .sym2(sym2), .metric(bm_a)
    );
    vsd_bmu #(.SW(SW), .BMW(BMW)) i_bmu_b (
        .rate3(rate3), .exp_bits(exp_b), .sym0(sym0), .sym1(sym1), .sym2(sym2), .metric(bm_b)
    );

    always_comb begin
        st_d   = st_q;
        bm_a_w = MW'(bm_a);
        bm_b_w = MW'(bm_b);
        ba     = bm_a_w[bit_idx];
        bb     = bm_b_w[bit_idx];
        cin_a  = first ? 1'b0 : st_q.cy_a;
        cin_b  = first ? 1'b0 : st_q.cy_b;
        bin    = first ? 1'b0 : st_q.brw;
        s_a    = pin0 ^ ba ^ cin_a;
        s_b    = pin1 ^ bb ^ cin_b;
        win    = st_q.brw ? st_q.cb : st_q.ca;
        if (shift_en) begin
            st_d.pm   = {st_q.pm[0], st_q.pm[MW-1:1]};
            st_d.ca   = {s_a, st_q.ca[MW-1:1]};
            st_d.cb   = {s_b, st_q.cb[MW-1:1]};
            st_d.cy_a = (pin0 & ba) | (pin0 & cin_a) | (ba & cin_a);
            st_d.cy_b = (pin1 & bb) | (pin1 & cin_b) | (bb & cin_b);
            // running borrow of (cand b - cand a): set at the end iff b < a
            st_d.brw  = (~s_b & s_a) | (~(s_b ^ s_a) & bin);
        end
        if (commit) begin
            st_d.pm = norm ? {1'b0, win[MW-2:0]} : win;
        end
    end

    assign pout    = st_q.pm[0];
    assign dec     = st_q.brw;
    assign win_msb = win[MW-1];
    assign pm_msb  = st_q.pm[MW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    no_carry_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (!st_q.cy_a && !st_q.cy_b));

    // R5
    tie_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (st_q.cb >= st_q.ca)) |-> !dec);
endmodule

// File: rtl/vsd_tbu.sv
module vsd_tbu #(
    parameter int K  = 4,
    parameter int TB = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic [2**(K-1)-1:0]   dec_vec,
    input  logic                  walk,
    input  logic                  walk_last,
    output logic                  out_valid,
    output logic                  out_bit
);
    localparam int NS  = 2 ** (K - 1);
    localparam int SSW = K - 1;
    localparam int PW  = $clog2(TB);
    localparam int FW  = $clog2(TB + 1);
    localparam logic [PW-1:0] PTR_TOP = PW'(TB - 1);
    localparam logic [FW-1:0] FULL    = FW'(TB);

    typedef struct packed {
        logic [TB-1:0][NS-1:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [SSW-1:0]        st;
        logic [FW-1:0]         fill;
        logic                  ov;
        logic                  ob;
    } tbu_t;

    tbu_t tb_d, tb_q;
    logic [NS-1:0] row;
    logic          pick;

    always_comb begin
        tb_d    = tb_q;
        tb_d.ov = 1'b0;
        row     = tb_q.mem[tb_q.rp];
        pick    = row[tb_q.st];
        if (commit) begin
            tb_d.mem[tb_q.wp] = dec_vec;
            tb_d.rp           = tb_q.wp;
            tb_d.wp           = (tb_q.wp == PTR_TOP) ? '0 : tb_q.wp + 1'b1;
            tb_d.st           = '0;
            if (tb_q.fill != FULL) begin
                tb_d.fill = tb_q.fill + 1'b1;
            end
        end
        if (walk) begin
            tb_d.st = {tb_q.st[SSW-2:0], pick};
            tb_d.rp = (tb_q.rp == '0) ? PTR_TOP : tb_q.rp - 1'b1;
            if (walk_last) begin
                tb_d.ov = (tb_q.fill == FULL);
                tb_d.ob = tb_q.st[SSW-1];
            end
        end
    end

    assign out_valid = tb_q.ov;
    assign out_bit   = tb_q.ob;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else begin
            tb_q <= tb_d;
        end
    end

    // R7
    walk_commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk |-> !commit);
endmodule

// File: rtl/vit_serial_dec.sv
module vit_serial_dec
    import vsd_pkg::*;
#(
    parameter int K  = 4,
    parameter int SW = 3,
    parameter int MW = 8,
    parameter int TB = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_rate3,
    input  logic [K-1:0]  cfg_gen0,
    input  logic [K-1:0]  cfg_gen1,
    input  logic [K-1:0]  cfg_gen2,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [SW-1:0] in_sym0,
    input  logic [SW-1:0] in_sym1,
    input  logic [SW-1:0] in_sym2,
    output logic          out_valid,
    output logic          out_bit
);
    localparam int NS  = 2 ** (K - 1);
    localparam int BMW = $clog2(3 * (2 ** SW - 1) + 1);
    localparam int IW  = $clog2(MW);
    localparam int CW  = $clog2(MW + TB + 1);
    localparam logic [CW-1:0] CYC_COMMIT = CW'(MW);
    localparam logic [CW-1:0] CYC_LAST   = CW'(MW + TB);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cyc;
        logic [SW-1:0] s0;
        logic [SW-1:0] s1;
        logic [SW-1:0] s2;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          running, shift_en, first, commit, walk, walk_last, norm;
    logic [IW-1:0] sh_idx;
    logic [NS-1:0] link, dec_vec, win_msb, pm_msb;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    ctl_d.phase = PH_RUN;
                    ctl_d.cyc   = '0;
                    ctl_d.s0    = in_sym0;
                    ctl_d.s1    = in_sym1;
                    ctl_d.s2    = in_sym2;
                end
            end
            default: begin
                if (ctl_q.cyc == CYC_LAST) begin
                    ctl_d.phase = PH_IDLE;
                end else begin
                    ctl_d.cyc = ctl_q.cyc + 1'b1;
                end
            end
        endcase
    end

    assign in_ready  = (ctl_q.phase == PH_IDLE);
    assign running   = (ctl_q.phase == PH_RUN);
    assign shift_en  = running && (ctl_q.cyc < CYC_COMMIT);
    assign first     = running && (ctl_q.cyc == '0);
    assign commit    = running && (ctl_q.cyc == CYC_COMMIT);
    assign walk      = running && (ctl_q.cyc > CYC_COMMIT);
    assign walk_last = running && (ctl_q.cyc == CYC_LAST);
    assign sh_idx    = ctl_q.cyc[IW-1:0];
    assign norm      = &win_msb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{PH_IDLE, '0, '0, '0, '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar n = 0; n < NS; n++) begin : g_node
        localparam int P0 = (2 * n) % NS;
        localparam int P1 = (2 * n + 1) % NS;
        vsd_acs_node #(
            .K(K), .SW(SW), .MW(MW), .BMW(BMW), .IW(IW), .IDX(n)
        ) i_node (
            .clk(clk), .rst_n(rst_n),
            .shift_en(shift_en), .first(first), .commit(commit), .norm(norm),
            .rate3(cfg_rate3), .gen0(cfg_gen0), .gen1(cfg_gen1), .gen2(cfg_gen2),
            .sym0(ctl_q.s0), .sym1(ctl_q.s1), .sym2(ctl_q.s2),
            .bit_idx(sh_idx),
            .pin0(link[P0]), .pin1(link[P1]),
            .pout(link[n]), .dec(dec_vec[n]),
            .win_msb(win_msb[n]), .pm_msb(pm_msb[n])
        );
    end

    vsd_tbu #(.K(K), .TB(TB)) i_tbu (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .dec_vec(dec_vec),
        .walk(walk), .walk_last(walk_last),
        .out_valid(out_valid), .out_bit(out_bit)
    );

    // R1
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R7
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7
    out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);

    // R6
    norm_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !(&pm_msb));
endmodule

// File: tb/test_vit_serial_dec.sv
module test_vit_serial_dec;
    localparam int MW = 8;
    localparam int TB = 32;
    localparam int MAXN = 256;
    localparam int M_STRONG = 0;
    localparam int M_ERR    = 1;
    localparam int M_WEAK   = 2;
    localparam int M_TIE    = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_rate3 = 1'b0;
    logic [3:0] cfg_gen0 = '0, cfg_gen1 = '0, cfg_gen2 = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [2:0] in_sym0 = '0, in_sym1 = '0, in_sym2 = '0;
    logic       out_valid, out_bit;

    int n_checks = 0;
    int n_fail   = 0;
    int n_acc    = 0;
    int n_got    = 0;
    logic exp_bits [MAXN];
    logic got_bits [MAXN];
    int   acc_at   [MAXN];
    logic [15:0] lfsr;

    always #5 clk = ~clk;

    vit_serial_dec i_vit_serial_dec (
        .clk(clk), .rst_n(rst_n), .cfg_rate3(cfg_rate3),
        .cfg_gen0(cfg_gen0), .cfg_gen1(cfg_gen1), .cfg_gen2(cfg_gen2),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_sym0(in_sym0), .in_sym1(in_sym1), .in_sym2(in_sym2),
        .out_valid(out_valid), .out_bit(out_bit)
    );

    always @(negedge clk) begin
        if (!rst_n) begin
            n_got = 0;
        end else if (out_valid) begin
            if (n_got < MAXN) begin
                got_bits[n_got] = out_bit;
                acc_at[n_got]   = n_acc;
            end
            n_got = n_got + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_sym0  = a;
        in_sym1  = b;
        in_sym2  = c;
        @(negedge clk);
        in_valid = 1'b0;
        n_acc++;
    endtask

    task automatic run_case(input string req, input logic r3, input logic [3:0] ga,
                            input logic [3:0] gb, input logic [3:0] gc, input int nst,
                            input int mode, input logic [15:0] seed, input bit measure);
        logic [2:0] es;
        logic [3:0] r;
        logic       u, c0, c1, c2;
        logic [2:0] s0, s1, s2;
        int         errs, low;
        rst_n = 1'b0;
        cfg_rate3 = r3; cfg_gen0 = ga; cfg_gen1 = gb; cfg_gen2 = gc;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: idle after reset
        check(in_ready == 1'b1, "R8 ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R8 no output after reset", int'(out_valid), 0);
        lfsr = seed; es = '0; n_acc = 0;
        for (int i = 0; i < nst; i++) begin
            u    = lfsr[0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r    = {u, es};
            c0   = ^(ga & r);
            c1   = ^(gb & r);
            c2   = ^(gc & r);
            es   = {u, es[2:1]};
            exp_bits[i] = (mode == M_TIE) ? 1'b0 : u;
            if (mode == M_WEAK) begin
                s0 = c0 ? 3'd4 : 3'd3; s1 = c1 ? 3'd4 : 3'd3; s2 = c2 ? 3'd4 : 3'd3;
            end else begin
                s0 = c0 ? 3'd7 : 3'd0; s1 = c1 ? 3'd7 : 3'd0; s2 = c2 ? 3'd7 : 3'd0;
            end
            if (mode == M_ERR && i >= 12 && (i % 12) == 11) begin
                s0 = 3'd7 - s0;
            end
            if (mode == M_TIE) begin
                s0 = 3'd0; s1 = 3'd7;
            end
            if (!r3) begin
                s2 = lfsr[6:4];
            end
            send(s0, s1, s2);
            if (measure && i == 0) begin
                low = 0;
                while (!in_ready) begin
                    low++;
                    @(negedge clk);
                end
                // R1: busy window after accepting a group
                check(low == MW + TB + 1, "R1 ready low clocks", low, MW + TB + 1);
            end
        end
        while (!in_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        // R7: count and latency of decoded bits
        check(n_got == nst - TB + 1, "R7 number of decoded bits", n_got, nst - TB + 1);
        check(acc_at[0] == TB, "R7 first output after group 32", acc_at[0], TB);
        errs = 0;
        for (int k = 0; k < n_got && k < MAXN; k++) begin
            if (got_bits[k] !== exp_bits[k]) errs++;
        end
        check(errs == 0, req, errs, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R2 R3: rate 1/2 clean, third symbol carries garbage and must not matter
        run_case("R2 R3 rate-half clean taps 1111/1101 decode errors",
                 1'b0, 4'b1111, 4'b1101, 4'b0000, 80, M_STRONG, 16'hACE1, 1'b1);
        // R2: another tap pair
        run_case("R2 rate-half clean taps 1011/1101 decode errors",
                 1'b0, 4'b1011, 4'b1101, 4'b0000, 70, M_STRONG, 16'h1357, 1'b0);
        // R4: isolated inverted symbols corrected
        run_case("R4 rate-half sparse inverted symbols decode errors",
                 1'b0, 4'b1111, 4'b1101, 4'b0000, 90, M_ERR, 16'h5A5A, 1'b0);
        // R3 R4: rate 1/3 with errors
        run_case("R3 R4 rate-third sparse inverted symbols decode errors",
                 1'b1, 4'b1111, 4'b1101, 4'b1011, 80, M_ERR, 16'h2468, 1'b0);
        // R6 R9: long weak run forces repeated normalization
        run_case("R3 R6 R9 rate-third weak symbols long run decode errors",
                 1'b1, 4'b1111, 4'b1101, 4'b1011, 140, M_WEAK, 16'hBEEF, 1'b0);
        // R5: identical taps make every branch metric equal
        run_case("R5 all-tie trellis decodes zeros errors",
                 1'b0, 4'b1101, 4'b1101, 4'b0000, 60, M_TIE, 16'h0F0F, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule